// File: doc/BRIEF.md
# Atomic-Launch Message Network Interface

This block sits between a processor and a message network at one node. To send, software writes the words of a message one at a time into a bank of staging registers. It can read any of them back, so a half-composed message can be saved and later restored across a context switch. Nothing reaches the outbound link while the message is being composed. A single launch command copies the whole staged message into an outbound buffer. The block then serializes that buffer as flits with a valid/ready handshake, marking the first flit as head and the last as tail. The message is either fully committed to the link or not started at all.

On the receive side, arriving flits fill a word ring buffer. Once every word of a message has arrived, the message counts as available. Software reads any word of the oldest available message by its index. A dispose command drops that message and exposes the next one. Arrival raises an interrupt unless software has set the interrupt mask, for example while it polls or while it runs an atomic section. Clearing the mask lets the interrupt through again. Reading the receive registers while no message is available returns zero and sets a sticky error flag.

Word 0 of every message is its header. Bits [3:0] hold the message length minus one, so a message has 1 to 16 words. Bits [31:24] carry the destination node, which the block passes on unchanged.

Top module: `msg_nic`

## Requirements
- R1: After reset, tx_valid, tx_busy, msg_avail, irq, irq_masked and rd_empty_err are 0, rx_ready is 1, and every staging word reads back as 0.
- R2: A write with st_wr_en stores st_wr_data at staging index st_wr_idx. That word reads back combinationally on st_rd_data when st_rd_idx selects it. Staging writes alone never raise tx_valid.
- R3: A launch sampled while tx_busy is 0 copies the staged message. From the next cycle, the block presents words 0 to N-1 on tx_data in index order, where N is header bits [3:0] plus 1. tx_busy stays 1 until the last flit is accepted.
- R4: tx_head is 1 only on the first flit of a message, and tx_tail is 1 only on the last. A one-word message has both markers set on its single flit.
- R5: While tx_valid is 1 and tx_ready is 0, tx_data, tx_head and tx_tail hold their values into the next cycle.
- R6: A launch sampled while tx_busy is 1 is ignored. It produces no flits, then or later.
- R7: Staging writes made after a launch do not change the message in flight, and they remain readable for a later launch.
- R8: msg_avail rises only once every word of a received message, as sized by its header, has been accepted. A message whose header alone has arrived is not available.
- R9: rd_en with msg_avail set returns, in the next cycle on rd_data, the word at offset rd_idx from the head of the oldest available message.
- R10: dispose with msg_avail set removes the oldest message and exposes the next one. dispose with no message available changes nothing.
- R11: irq equals msg_avail while irq_masked is 0, and is 0 while irq_masked is 1. irq_mask_set sets irq_masked and irq_mask_clr clears it, with set winning if both are asserted.
- R12: rd_en with no message available makes rd_data 0 in the next cycle and sets rd_empty_err, which stays set until reset.
- R13: rx_ready is 0 exactly when the receive buffer holds RX_WORDS words, and it returns to 1 once a dispose frees space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_wr_en | input | 1 | Staging word write strobe |
| st_wr_idx | input | IW | Staging word index to write |
| st_wr_data | input | W | Staging word value |
| st_rd_idx | input | IW | Staging word index to read back |
| st_rd_data | output | W | Staging readback value |
| launch | input | 1 | Commit the staged message for transmission |
| tx_busy | output | 1 | A launched message is still serializing |
| tx_valid | output | 1 | Outbound flit valid |
| tx_ready | input | 1 | Network accepts the outbound flit |
| tx_data | output | W | Outbound flit word |
| tx_head | output | 1 | Flit is the first of its message |
| tx_tail | output | 1 | Flit is the last of its message |
| rx_valid | input | 1 | Inbound flit valid |
| rx_ready | output | 1 | Receive buffer has room |
| rx_data | input | W | Inbound flit word |
| rd_en | input | 1 | Read a word of the current received message |
| rd_idx | input | IW | Word offset within the current message |
| rd_data | output | W | Word read, valid the cycle after rd_en |
| dispose | input | 1 | Drop the current received message |
| msg_avail | output | 1 | At least one complete message is held |
| irq_mask_set | input | 1 | Mask arrival interrupts |
| irq_mask_clr | input | 1 | Unmask arrival interrupts |
| irq_masked | output | 1 | Current interrupt mask state |
| irq | output | 1 | Arrival interrupt |
| rd_empty_err | output | 1 | Sticky flag for a read with no message present |

## Verification
The bench builds the block with 32-bit words, 16 staging words and a 32-word receive buffer. At these sizes two maximum-length messages fill the receive buffer exactly, so the full condition on rx_ready can be reached. The earlier short messages also push the ring pointers across their wrap point before that fill. An 8-word launch under a stalling tx_ready leaves enough busy cycles to rewrite the staging words and to issue a refused second launch while the first message is still in flight.

// File: rtl/msg_nic_pkg.sv
package msg_nic_pkg;
    // Header word: length-minus-one sits at the bottom of word 0
    localparam int LEN_LSB = 0;
    // Destination field position in word 0 (carried, not decoded here)
    localparam int DEST_LSB = 24;
    localparam int DEST_W   = 8;
endpackage

// File: rtl/msg_nic_stage.sv
module msg_nic_stage #(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IW-1:0]             wr_idx,
    input  logic [W-1:0]              wr_data,
    input  logic [IW-1:0]             rd_idx,
    output logic [W-1:0]              rd_data,
    output logic [DEPTH-1:0][W-1:0]   words
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] words;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.words[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.words[rd_idx];
    assign words   = s_q.words;
endmodule

// File: rtl/msg_nic_tx.sv
module msg_nic_tx
    import msg_nic_pkg::*;
#(
    parameter  int W     = 32,
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      launch,
    input  logic [DEPTH-1:0][W-1:0]   stage_words,
    input  logic                      tx_ready,
    output logic                      tx_valid,
    output logic [W-1:0]              tx_data,
    output logic                      tx_head,
    output logic                      tx_tail,
    output logic                      busy
);
    typedef struct packed {
        logic                    busy;
        logic [IW-1:0]           cnt;
        logic [IW-1:0]           last;
        logic [DEPTH-1:0][W-1:0] snap;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (tx_ready) begin
                if (t_q.cnt == t_q.last) t_d.busy = 1'b0;
                else                     t_d.cnt  = t_q.cnt + IW'(1);
            end
        end else if (launch) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
            t_d.snap = stage_words;
            t_d.last = stage_words[0][LEN_LSB +: IW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy     = t_q.busy;
    assign tx_valid = t_q.busy;
    assign tx_data  = t_q.snap[t_q.cnt];
    assign tx_head  = t_q.busy && (t_q.cnt == '0);
    assign tx_tail  = t_q.busy && (t_q.cnt == t_q.last);
endmodule

// File: rtl/msg_nic_rx.sv
module msg_nic_rx
    import msg_nic_pkg::*;
#(
    parameter  int W      = 32,
    parameter  int MSG_W  = 16,
    parameter  int DEPTH  = 32,
    localparam int IW     = $clog2(MSG_W),
    localparam int PW     = $clog2(DEPTH),
    localparam int UW     = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [W-1:0]  rx_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          dispose,
    output logic          msg_avail,
    output logic          rd_err
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ring;
        logic [PW-1:0]           wptr;
        logic [PW-1:0]           rptr;
        logic [UW-1:0]           used;
        logic [UW-1:0]           msgs;
        logic                    mid;
        logic [IW-1:0]           rem;
        logic [W-1:0]            rd_data;
        logic                    err;
    } rx_t;

    rx_t r_d, r_q;

    logic          acc;
    logic          disp_ok;
    logic          done;
    logic [UW-1:0] head_len;

    assign rx_ready = r_q.used < UW'(DEPTH);
    assign acc      = rx_valid && rx_ready;
    assign disp_ok  = dispose && (r_q.msgs != '0);
    assign head_len = UW'(r_q.ring[r_q.rptr][LEN_LSB +: IW]) + UW'(1);

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (acc) begin
            r_d.ring[r_q.wptr] = rx_data;
            r_d.wptr           = r_q.wptr + PW'(1);
            if (!r_q.mid) begin
                if (rx_data[LEN_LSB +: IW] == '0) begin
                    done = 1'b1;
                end else begin
                    r_d.mid = 1'b1;
                    r_d.rem = rx_data[LEN_LSB +: IW];
                end
            end else begin
                r_d.rem = r_q.rem - IW'(1);
                if (r_q.rem == IW'(1)) begin
                    r_d.mid = 1'b0;
                    done    = 1'b1;
                end
            end
        end
        r_d.used = r_q.used + UW'(acc) - (disp_ok ? head_len : '0);
        r_d.msgs = r_q.msgs + UW'(done) - UW'(disp_ok);
        if (disp_ok) r_d.rptr = r_q.rptr + head_len[PW-1:0];
        if (rd_en) begin
            if (r_q.msgs != '0) begin
                r_d.rd_data = r_q.ring[r_q.rptr + PW'(rd_idx)];
            end else begin
                r_d.rd_data = '0;
                r_d.err     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign msg_avail = r_q.msgs != '0;
    assign rd_data   = r_q.rd_data;
    assign rd_err    = r_q.err;
endmodule

// File: rtl/msg_nic.sv
module msg_nic #(
    parameter  int W           = 32,
    parameter  int STAGE_WORDS = 16,
    parameter  int RX_WORDS    = 32,
    localparam int IW          = $clog2(STAGE_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_wr_en,
    input  logic [IW-1:0] st_wr_idx,
    input  logic [W-1:0]  st_wr_data,
    input  logic [IW-1:0] st_rd_idx,
    output logic [W-1:0]  st_rd_data,
    input  logic          launch,
    output logic          tx_busy,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [W-1:0]  tx_data,
    output logic          tx_head,
    output logic          tx_tail,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [W-1:0]  rx_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          dispose,
    output logic          msg_avail,
    input  logic          irq_mask_set,
    input  logic          irq_mask_clr,
    output logic          irq_masked,
    output logic          irq,
    output logic          rd_empty_err
);
    logic [STAGE_WORDS-1:0][W-1:0] stage_words;

    msg_nic_stage #(.W(W), .DEPTH(STAGE_WORDS)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .rd_idx  (st_rd_idx),
        .rd_data (st_rd_data),
        .words   (stage_words)
    );

    msg_nic_tx #(.W(W), .DEPTH(STAGE_WORDS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .stage_words (stage_words),
        .tx_ready    (tx_ready),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_head     (tx_head),
        .tx_tail     (tx_tail),
        .busy        (tx_busy)
    );

    msg_nic_rx #(.W(W), .MSG_W(STAGE_WORDS), .DEPTH(RX_WORDS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .dispose   (dispose),
        .msg_avail (msg_avail),
        .rd_err    (rd_empty_err)
    );

    typedef struct packed {
        logic mask;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (irq_mask_set)      i_d.mask = 1'b1;
        else if (irq_mask_clr) i_d.mask = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign irq_masked = i_q.mask;
    assign irq        = msg_avail && !i_q.mask;
endmodule

// File: rtl/msg_nic_chk.sv
module msg_nic_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         launch,
    input logic         tx_busy,
    input logic         tx_valid,
    input logic         tx_ready,
    input logic [W-1:0] tx_data,
    input logic         tx_head,
    input logic         tx_tail,
    input logic         rd_en,
    input logic         msg_avail,
    input logic [W-1:0] rd_data,
    input logic         rd_empty_err,
    input logic         irq_mask_set,
    input logic         irq
);
    // R3
    tx_start_needs_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(launch));

    // R5
    tx_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                     && $stable(tx_head) && $stable(tx_tail)));

    // R4
    tx_head_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_tail) |=> (tx_valid && !tx_head));

    // R6
    tx_refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && tx_busy && !(tx_valid && tx_ready && tx_tail)) |=> tx_busy);

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask_set |=> !irq);

    // R12
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !msg_avail) |=> (rd_empty_err && rd_data == '0));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty_err |=> rd_empty_err);
endmodule

bind msg_nic msg_nic_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .tx_busy      (tx_busy),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_head      (tx_head),
    .tx_tail      (tx_tail),
    .rd_en        (rd_en),
    .msg_avail    (msg_avail),
    .rd_data      (rd_data),
    .rd_empty_err (rd_empty_err),
    .irq_mask_set (irq_mask_set),
    .irq          (irq)
);

// File: tb/sim_msg_nic.sv
`timescale 1ns/1ps
module sim_msg_nic;
    localparam int W  = 32;
    localparam int SW = 16;
    localparam int RW = 32;
    localparam int IW = $clog2(SW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_wr_en = 1'b0;
    logic [IW-1:0] st_wr_idx = '0;
    logic [W-1:0]  st_wr_data = '0;
    logic [IW-1:0] st_rd_idx = '0;
    logic [W-1:0]  st_rd_data;
    logic          launch = 1'b0;
    logic          tx_busy, tx_valid, tx_head, tx_tail;
    logic          tx_ready = 1'b1;
    logic [W-1:0]  tx_data;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [W-1:0]  rx_data = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_data;
    logic          dispose = 1'b0;
    logic          msg_avail;
    logic          irq_mask_set = 1'b0, irq_mask_clr = 1'b0;
    logic          irq_masked, irq, rd_empty_err;

    int checks = 0;
    int fails  = 0;
    bit stall  = 1'b0;
    bit finished = 1'b0;
    logic [W+1:0] exp_q[$];

    always #2.5 clk = ~clk;

    msg_nic #(.W(W), .STAGE_WORDS(SW), .RX_WORDS(RW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [W-1:0] hdr(input logic [7:0] dest, input logic [3:0] lm1);
        return {dest, 20'h0, lm1};
    endfunction

    // ready pattern: stalls every other cycle when enabled
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 tx_ready = !stall || cyc[0];
    end

    // monitor / scoreboard
    bit           hold_pend = 1'b0;
    logic [W+1:0] held;
    always @(negedge clk) if (rst_n) begin
        if (hold_pend)
            chk(tx_valid && {tx_data, tx_head, tx_tail} == held, "R5 stall hold",
                tx_data, held[W+1:2]);
        if (tx_valid && !tx_ready) begin
            hold_pend = 1'b1;
            held = {tx_data, tx_head, tx_tail};
        end else hold_pend = 1'b0;
        if (tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected flit", tx_data, '0);
            end else begin
                logic [W+1:0] e;
                e = exp_q.pop_front();
                chk({tx_data, tx_head, tx_tail} == e, "R3/R4 flit",
                    {tx_data[W-3:0], tx_head, tx_tail}, {e[W-1:0]});
            end
        end
    end

    task automatic stage_wr(input int idx, input logic [W-1:0] d);
        st_wr_en = 1'b1; st_wr_idx = IW'(idx); st_wr_data = d;
        tick();
        st_wr_en = 1'b0;
    endtask

    // driver: launch and push expected flits
    task automatic do_launch(input logic [W-1:0] words[], input bool_push);
        launch = 1'b1;
        tick();
        launch = 1'b0;
        if (bool_push) begin
            for (int i = 0; i < words.size(); i++)
                exp_q.push_back({words[i], i == 0, i == words.size() - 1});
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || tx_busy) tick();
    endtask

    task automatic rx_send(input logic [W-1:0] d);
        rx_valid = 1'b1; rx_data = d;
        while (!rx_ready) tick();
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic pulse_rd(input int idx);
        rd_en = 1'b1; rd_idx = IW'(idx);
        tick();
        rd_en = 1'b0;
    endtask

    task automatic pulse_dispose();
        dispose = 1'b1;
        tick();
        dispose = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] m[];
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(!tx_valid && !tx_busy && !msg_avail && !irq && !irq_masked && !rd_empty_err,
            "R1 reset outputs", {tx_valid, tx_busy, msg_avail, irq, irq_masked, rd_empty_err}, '0);
        chk(rx_ready, "R1 rx_ready", rx_ready, 1);
        st_rd_idx = 4'd7; #1;
        chk(st_rd_data == '0, "R1 staging zero", st_rd_data, '0);

        // R2 staging writes and readback, no flit before launch
        m = new[4];
        m[0] = hdr(8'h05, 4'd3); m[1] = 32'h1111_0001; m[2] = 32'h2222_0002; m[3] = 32'h3333_0003;
        for (int i = 0; i < 4; i++) stage_wr(i, m[i]);
        st_rd_idx = 4'd2; #1;
        chk(st_rd_data == m[2], "R2 readback", st_rd_data, m[2]);
        repeat (3) tick();
        chk(!tx_valid, "R2 no flit before launch", tx_valid, 0);

        // R3 R4 four-word message, ready always high
        do_launch(m, 1);
        chk(tx_busy, "R3 busy after launch", tx_busy, 1);
        drain();
        chk(!tx_busy, "R3 idle after tail", tx_busy, 0);

        // R5 R6 R7 eight-word message under stall, refused launch, rewrite stage
        m = new[8];
        m[0] = hdr(8'h0A, 4'd7);
        for (int i = 1; i < 8; i++) m[i] = 32'hA000_0000 + i;
        for (int i = 0; i < 8; i++) stage_wr(i, m[i]);
        stall = 1'b1;
        do_launch(m, 1);
        stage_wr(0, hdr(8'h0B, 4'd1));
        stage_wr(1, 32'h0000_BEEF);
        do_launch(m, 0);
        chk(tx_busy, "R6 busy kept after refused launch", tx_busy, 1);
        drain();
        stall = 1'b0;
        repeat (4) tick();
        chk(!tx_valid, "R6 refused launch sends nothing", tx_valid, 0);
        st_rd_idx = 4'd1; #1;
        chk(st_rd_data == 32'h0000_BEEF, "R7 staged rewrite kept", st_rd_data, 32'h0000_BEEF);
        m = new[2];
        m[0] = hdr(8'h0B, 4'd1); m[1] = 32'h0000_BEEF;
        do_launch(m, 1);
        drain();

        // R4 single-word message carries head and tail
        m = new[1];
        m[0] = hdr(8'h09, 4'd0);
        stage_wr(0, m[0]);
        do_launch(m, 1);
        drain();

        // R8 R9 R11 receive side
        rx_send(hdr(8'h01, 4'd2));
        chk(!msg_avail, "R8 header only not available", msg_avail, 0);
        rx_send(32'hC0DE_0001);
        rx_send(32'hC0DE_0002);
        chk(msg_avail, "R8 complete message available", msg_avail, 1);
        chk(irq, "R11 irq unmasked", irq, 1);
        pulse_rd(1);
        chk(rd_data == 32'hC0DE_0001, "R9 read offset 1", rd_data, 32'hC0DE_0001);
        rx_send(hdr(8'h02, 4'd1));
        rx_send(32'hD00D_0001);
        irq_mask_set = 1'b1; tick(); irq_mask_set = 1'b0;
        chk(!irq && irq_masked && msg_avail, "R11 masked irq", irq, 0);
        pulse_dispose();
        pulse_rd(0);
        chk(rd_data == hdr(8'h02, 4'd1), "R10 next message exposed", rd_data, hdr(8'h02, 4'd1));
        pulse_rd(1);
        chk(rd_data == 32'hD00D_0001, "R9 read second message", rd_data, 32'hD00D_0001);
        irq_mask_clr = 1'b1; tick(); irq_mask_clr = 1'b0;
        chk(irq && !irq_masked, "R11 unmask restores irq", irq, 1);
        pulse_dispose();
        chk(!msg_avail && !irq, "R10 last dispose empties", msg_avail, 0);
        pulse_dispose();
        chk(!msg_avail && rx_ready, "R10 dispose when empty ignored", msg_avail, 0);

        // R12 empty read
        chk(!rd_empty_err, "R12 no error yet", rd_empty_err, 0);
        pulse_rd(0);
        chk(rd_data == '0 && rd_empty_err, "R12 empty read", rd_data, '0);
        repeat (3) tick();
        chk(rd_empty_err, "R12 error sticky", rd_empty_err, 1);

        // R13 fill buffer with two 16-word messages (pointers wrap)
        for (int k = 0; k < 2; k++) begin
            rx_send(hdr(8'h03, 4'd15));
            for (int i = 1; i < 16; i++) rx_send(32'hE000_0000 + (k << 8) + i);
        end
        chk(!rx_ready, "R13 buffer full", rx_ready, 0);
        pulse_rd(5);
        chk(rd_data == 32'hE000_0005, "R9 read after wrap", rd_data, 32'hE000_0005);
        pulse_dispose();
        chk(rx_ready, "R13 room after dispose", rx_ready, 1);
        pulse_rd(5);
        chk(rd_data == 32'hE000_0105, "R10 second full message", rd_data, 32'hE000_0105);

        repeat (2) tick();
        finish_run();
    end
endmodule